// File: doc/BRIEF.md
# Windowed Register File with Overlapping Procedure Windows

This block is a register file for a processor whose procedures each see a fixed-size set of logical registers. The registers are taken from a physical array that is split into a bank of globals, shared by every procedure, and a ring of procedure windows. A window pointer selects the active window. Each logical index is translated to a physical index from that pointer. A call advances the pointer and a return moves it back. The registers a caller uses to pass arguments are the same physical registers that the callee reads as its incoming arguments, so no values are copied.

The windowed part is circular. A resident-window counter tracks how many windows still hold live procedure state. A call that would reuse a window still owned by a live caller is refused with an overflow trap, and the block reports the oldest resident window for software to save. A return that finds no resident caller window is refused with an underflow trap, and the block reports the window to be restored. Software signals that a save or restore has finished, and then retries the call or return. The block does not move any data to or from memory.

With the default sizes (8 globals, 10 privates and 6 overlap registers per window, 8 windows) the array holds 136 physical registers, and each procedure sees 30 logical ones.

Top module: `rwin_regfile`

## Requirements
- R1: After a synchronous active-low reset the window pointer is 0, one window is resident, no trap is raised, and every logical register reads zero.
- R2: Logical indices 0 to 7 are globals. They map to the same physical registers in every window, so a value written in one window reads back unchanged in every other window.
- R3: Logical indices 8 to 13 are incoming arguments, 14 to 23 are private registers and 24 to 29 are outgoing arguments. A value written to outgoing argument k (index 24+k) before a call reads back from incoming argument k (index 8+k) after the call.
- R4: Private registers (14 to 23) of a window keep their values while deeper calls run and write their own private and outgoing registers. They read back unchanged after the returns.
- R5: An accepted call increments the window pointer modulo 8, and an accepted return decrements it modulo 8, at the clock edge.
- R6: A call made while 7 windows are resident raises the overflow trap in the same cycle and leaves the pointer unchanged. The spill-window output then equals (pointer - resident + 1) mod 8, the oldest resident window.
- R7: A spill-done pulse lowers the resident count by one. A call retried after it is accepted.
- R8: A return made while one window is resident raises the underflow trap in the same cycle and leaves the pointer unchanged. The fill-window output equals (pointer - 1) mod 8.
- R9: A fill-done pulse raises the resident count by one. A return retried after it is accepted.
- R10: Reads are combinational. A read of the register being written in the same cycle returns the old value, and the new value is returned from the next cycle on.
- R11: A write issued in the same cycle as a call uses the window that was active before the call.
- R12: The ring wraps: outgoing argument k of window 7 is incoming argument k of window 0.
- R13: Logical indices 30 and 31 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| call_i | input | 1 | Call strobe, moves the window forward |
| ret_i | input | 1 | Return strobe, moves the window back |
| spill_done_i | input | 1 | Software has saved the oldest window |
| fill_done_i | input | 1 | Software has restored the caller window |
| we_i | input | 1 | Write enable |
| waddr_i | input | 5 | Logical write index |
| wdata_i | input | 32 | Write data |
| raddr_a_i | input | 5 | Logical read index, port A |
| rdata_a_o | output | 32 | Read data, port A |
| raddr_b_i | input | 5 | Logical read index, port B |
| rdata_b_o | output | 32 | Read data, port B |
| cur_win_o | output | 3 | Active window pointer |
| spill_win_o | output | 3 | Oldest resident window, to save on overflow |
| fill_win_o | output | 3 | Caller window, to restore on underflow |
| ovf_trap_o | output | 1 | Call refused: no free window |
| unf_trap_o | output | 1 | Return refused: caller not resident |

## Verification
Read data and both trap flags are combinational, so the bench checks them in the cycle the stimulus is applied, before the next rising edge. Pointer moves, counter changes and writes take effect at the next edge, so the bench checks their effects one cycle after the strobe. Samples are taken 1 ns after a rising edge, or later in the same cycle. For the same-cycle read of R10 the bench checks the old value before the edge and the new value just after it. The bench keeps its own record of the window pointer, resident count and expected register values. It works these out with modulo arithmetic over a full descent through every window, two wraps of the ring, and a return back down to an underflow.

// File: rtl/rwin_pkg.sv
// Package: shared types and helpers for the windowed register file.
// Assumes: all modulo helpers are called with n >= 1.
package rwin_pkg;

    // Which window-state change the control accepts in a cycle
    typedef enum logic [2:0] {
        WACT_NONE,
        WACT_CALL,
        WACT_RET,
        WACT_SPILL,
        WACT_FILL
    } win_act_e;

    // (a + b) mod n on plain integers
    function automatic int unsigned mod_add(int unsigned a, int unsigned b, int unsigned n);
        return (a + b) % n;
    endfunction

endpackage

// File: rtl/rwin_map.sv
// Module: rwin_map
// Turns a logical register index into a physical index for a given window.
// Logical order: globals, incoming, private, outgoing. The outgoing group of
// window w is the incoming group of window (w+1) mod NWIN.
// Assumes: indices at or above the logical count are flagged invalid and
// mapped to physical 0. The consumer must gate them.
module rwin_map
    import rwin_pkg::*;
#(
    parameter int NGLB = 8,
    parameter int NLOC = 10,
    parameter int NOVL = 6,
    parameter int NWIN = 8,
    localparam int STRIDE = NLOC + NOVL,
    localparam int NPHYS  = NGLB + NWIN * STRIDE,
    localparam int NLOG   = 2 * NOVL + NLOC + NGLB,
    localparam int LOG_W  = $clog2(NLOG),
    localparam int PHY_W  = $clog2(NPHYS),
    localparam int WIN_W  = $clog2(NWIN)
) (
    input  logic [WIN_W-1:0] win_i,
    input  logic [LOG_W-1:0] lidx_i,
    output logic [PHY_W-1:0] pidx_o,
    output logic             valid_o
);

    // Combinational translation of one logical index
    always_comb begin
        int unsigned li;
        int unsigned k;
        int unsigned nxt;
        int unsigned p;
        li  = int'(lidx_i);
        nxt = mod_add(int'(win_i), 1, NWIN);
        k   = 0;
        if (li < NGLB) begin
            p = li;
        end else begin
            k = li - NGLB;
            if (k < STRIDE)
                p = NGLB + int'(win_i) * STRIDE + k;
            else
                p = NGLB + nxt * STRIDE + (k - STRIDE);
        end
        valid_o = (li < NLOG);
        if (!valid_o)
            p = 0;
        pidx_o = PHY_W'(p);
    end

endmodule

// File: rtl/rwin_ctrl.sv
// Module: rwin_ctrl
// Keeps the window pointer and the resident-window count, and decides whether
// call, return, spill-done and fill-done are accepted. It raises the traps.
// Assumes: at most one strobe per cycle. If several are raised, the priority is
// call, then return, then spill-done, then fill-done.
module rwin_ctrl
    import rwin_pkg::*;
#(
    parameter int NWIN = 8,
    localparam int WIN_W = $clog2(NWIN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             call_i,
    input  logic             ret_i,
    input  logic             spill_done_i,
    input  logic             fill_done_i,
    output logic [WIN_W-1:0] cwp_o,
    output logic [WIN_W-1:0] spill_win_o,
    output logic [WIN_W-1:0] fill_win_o,
    output logic             ovf_o,
    output logic             unf_o
);

    logic [WIN_W-1:0] cwp_q;
    logic [WIN_W-1:0] rcnt_q;
    win_act_e         act;
    logic             full;
    logic             alone;

    assign full  = (int'(rcnt_q) == NWIN - 1);
    assign alone = (int'(rcnt_q) == 1);

    // Choose the accepted action and raise refused-strobe traps
    always_comb begin
        act   = WACT_NONE;
        ovf_o = 1'b0;
        unf_o = 1'b0;
        if (call_i) begin
            ovf_o = full;
            if (!full) act = WACT_CALL;
        end else if (ret_i) begin
            unf_o = alone;
            if (!alone) act = WACT_RET;
        end else if (spill_done_i && !alone) begin
            act = WACT_SPILL;
        end else if (fill_done_i && !full) begin
            act = WACT_FILL;
        end
    end

    // Update pointer and resident count at the clock edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cwp_q  <= '0;
            rcnt_q <= WIN_W'(1);
        end else begin
            unique case (act)
                WACT_CALL: begin
                    cwp_q  <= WIN_W'(mod_add(int'(cwp_q), 1, NWIN));
                    rcnt_q <= rcnt_q + 1'b1;
                end
                WACT_RET: begin
                    cwp_q  <= WIN_W'(mod_add(int'(cwp_q), NWIN - 1, NWIN));
                    rcnt_q <= rcnt_q - 1'b1;
                end
                WACT_SPILL: rcnt_q <= rcnt_q - 1'b1;
                WACT_FILL:  rcnt_q <= rcnt_q + 1'b1;
                default: ;
            endcase
        end
    end

    // Report the oldest resident window and the caller window
    always_comb begin
        spill_win_o = WIN_W'(mod_add(int'(cwp_q), NWIN + 1 - int'(rcnt_q), NWIN));
        fill_win_o  = WIN_W'(mod_add(int'(cwp_q), NWIN - 1, NWIN));
    end

    assign cwp_o = cwp_q;

    p_count_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rcnt_q) >= 1) && (int'(rcnt_q) <= NWIN - 1));

    p_call_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && !ovf_o) |=> (int'(cwp_q) == (int'($past(cwp_q)) + 1) % NWIN));

    p_ret_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!call_i && ret_i && !unf_o) |=> (int'(cwp_q) == (int'($past(cwp_q)) + NWIN - 1) % NWIN));

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> $stable(cwp_q) && $stable(rcnt_q));

    p_underflow_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        unf_o |=> $stable(cwp_q) && $stable(rcnt_q));

    p_spill_frees_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!call_i && !ret_i && spill_done_i && !alone) |=> (rcnt_q == $past(rcnt_q) - 1'b1));

    p_traps_apart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({ovf_o, unf_o}) <= 1);

endmodule

// File: rtl/rwin_regfile.sv
// Module: rwin_regfile (top)
// Register file built from a global bank and a ring of overlapping windows.
// It has two combinational read ports and one write port, plus call and
// return control with overflow and underflow traps.
// Assumes: the caller raises at most one of call, return, spill-done and
// fill-done per cycle. Saving and restoring windows is left to software.
module rwin_regfile
    import rwin_pkg::*;
#(
    parameter int NGLB = 8,
    parameter int NLOC = 10,
    parameter int NOVL = 6,
    parameter int NWIN = 8,
    parameter int DW   = 32,
    localparam int STRIDE = NLOC + NOVL,
    localparam int NPHYS  = NGLB + NWIN * STRIDE,
    localparam int NLOG   = 2 * NOVL + NLOC + NGLB,
    localparam int LOG_W  = $clog2(NLOG),
    localparam int PHY_W  = $clog2(NPHYS),
    localparam int WIN_W  = $clog2(NWIN),
    localparam int NPORT  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             call_i,
    input  logic             ret_i,
    input  logic             spill_done_i,
    input  logic             fill_done_i,
    input  logic             we_i,
    input  logic [LOG_W-1:0] waddr_i,
    input  logic [DW-1:0]    wdata_i,
    input  logic [LOG_W-1:0] raddr_a_i,
    output logic [DW-1:0]    rdata_a_o,
    input  logic [LOG_W-1:0] raddr_b_i,
    output logic [DW-1:0]    rdata_b_o,
    output logic [WIN_W-1:0] cur_win_o,
    output logic [WIN_W-1:0] spill_win_o,
    output logic [WIN_W-1:0] fill_win_o,
    output logic             ovf_trap_o,
    output logic             unf_trap_o
);

    logic [DW-1:0]    regs [NPHYS];
    logic [WIN_W-1:0] cwp;
    logic [LOG_W-1:0] laddr [NPORT];
    logic [PHY_W-1:0] paddr [NPORT];
    logic             pvalid [NPORT];

    rwin_ctrl #(.NWIN(NWIN)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .call_i       (call_i),
        .ret_i        (ret_i),
        .spill_done_i (spill_done_i),
        .fill_done_i  (fill_done_i),
        .cwp_o        (cwp),
        .spill_win_o  (spill_win_o),
        .fill_win_o   (fill_win_o),
        .ovf_o        (ovf_trap_o),
        .unf_o        (unf_trap_o)
    );

    // Port 0 writes, ports 1 and 2 read; all translate in the current window
    assign laddr[0] = waddr_i;
    assign laddr[1] = raddr_a_i;
    assign laddr[2] = raddr_b_i;

    for (genvar gp = 0; gp < NPORT; gp++) begin : g_map
        rwin_map #(
            .NGLB (NGLB),
            .NLOC (NLOC),
            .NOVL (NOVL),
            .NWIN (NWIN)
        ) u_map (
            .win_i   (cwp),
            .lidx_i  (laddr[gp]),
            .pidx_o  (paddr[gp]),
            .valid_o (pvalid[gp])
        );
    end

    // Storage: clear on reset, else write one valid physical register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NPHYS; i++)
                regs[i] <= '0;
        end else if (we_i && pvalid[0]) begin
            regs[paddr[0]] <= wdata_i;
        end
    end

    // Combinational reads, zero for indices beyond the logical set
    assign rdata_a_o = pvalid[1] ? regs[paddr[1]] : '0;
    assign rdata_b_o = pvalid[2] ? regs[paddr[2]] : '0;
    assign cur_win_o = cwp;

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (cur_win_o == '0) && (rdata_a_o == '0) && (rdata_b_o == '0));

    p_invalid_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(raddr_a_i) >= NLOG) |-> (rdata_a_o == '0));

    p_phys_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pvalid[0] |-> (int'(paddr[0]) < NPHYS));

endmodule

// File: tb/sim_rwin_regfile.sv
`timescale 1ns/100ps
module sim_rwin_regfile;

    localparam int NW = 8;
    localparam int GB = 0;   // first global index
    localparam int IB = 8;   // first incoming index
    localparam int LB = 14;  // first private index
    localparam int OB = 24;  // first outgoing index

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        call_i = 0, ret_i = 0, spill_done_i = 0, fill_done_i = 0;
    logic        we_i = 0;
    logic [4:0]  waddr_i = '0, raddr_a_i = '0, raddr_b_i = '0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_a_o, rdata_b_o;
    logic [2:0]  cur_win_o, spill_win_o, fill_win_o;
    logic        ovf_trap_o, unf_trap_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;
    logic [31:0] exp_loc [NW][10];

    always #2 clk = ~clk;

    rwin_regfile u0 (
        .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i),
        .spill_done_i(spill_done_i), .fill_done_i(fill_done_i),
        .we_i(we_i), .waddr_i(waddr_i), .wdata_i(wdata_i),
        .raddr_a_i(raddr_a_i), .rdata_a_o(rdata_a_o),
        .raddr_b_i(raddr_b_i), .rdata_b_o(rdata_b_o),
        .cur_win_o(cur_win_o), .spill_win_o(spill_win_o), .fill_win_o(fill_win_o),
        .ovf_trap_o(ovf_trap_o), .unf_trap_o(unf_trap_o)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic rd_a(string req, int addr, logic [31:0] exp);
        raddr_a_i = 5'(addr);
        #0.5;
        chk(req, rdata_a_o, exp);
    endtask

    task automatic rd_b(string req, int addr, logic [31:0] exp);
        raddr_b_i = 5'(addr);
        #0.5;
        chk(req, rdata_b_o, exp);
    endtask

    task automatic wr(int addr, logic [31:0] val);
        we_i = 1; waddr_i = 5'(addr); wdata_i = val;
        step();
        we_i = 0;
    endtask

    task automatic fill_locals(int w);
        for (int j = 0; j < 10; j++) begin
            exp_loc[w][j] = 32'hA000 + 32'(w * 256 + j);
            wr(LB + j, exp_loc[w][j]);
        end
    endtask

    task automatic check_locals(string req, int w);
        for (int j = 0; j < 10; j++)
            rd_a(req, LB + j, exp_loc[w][j]);
    endtask

    task automatic good_call(int to);
        call_i = 1; #0.5;
        chk("R6 no trap on call", 32'(ovf_trap_o), 0);
        step(); call_i = 0;
        chk("R5 call advance", 32'(cur_win_o), 32'(to));
    endtask

    task automatic good_ret(int to);
        ret_i = 1; #0.5;
        chk("R8 no trap on return", 32'(unf_trap_o), 0);
        step(); ret_i = 0;
        chk("R5 return back", 32'(cur_win_o), 32'(to));
    endtask

    task automatic pulse_spill();
        spill_done_i = 1; step(); spill_done_i = 0;
    endtask

    // Watchdog: count a failure and still print the summary
    initial begin
        #800000;
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1;
        step();
        // R1 reset state
        chk("R1 window", 32'(cur_win_o), 0);
        chk("R1 traps", 32'({ovf_trap_o, unf_trap_o}), 0);
        for (int a = 0; a < 32; a++) rd_a("R1 zero", a, 0);

        // R2 globals
        for (int g = 0; g < 8; g++) wr(GB + g, 32'h1000 + 32'(g));
        fill_locals(0);

        // Descend windows 0..5 -> 6 with argument passing (R3)
        for (int w = 0; w < 6; w++) begin
            if (w > 0) fill_locals(w);
            for (int k = 0; k < 6; k++) wr(OB + k, 32'hB000 + 32'(w * 256 + k));
            good_call(w + 1);
            for (int k = 0; k < 6; k++) rd_b("R3 out to in", IB + k, 32'hB000 + 32'(w * 256 + k));
            for (int g = 0; g < 8; g++) rd_b("R2 global", GB + g, 32'h1000 + 32'(g));
        end

        // R6 overflow in window 6 with 7 residents
        fill_locals(6);
        call_i = 1; #0.5;
        chk("R6 overflow trap", 32'(ovf_trap_o), 1);
        chk("R6 oldest window", 32'(spill_win_o), 0);
        step(); call_i = 0;
        chk("R6 pointer held", 32'(cur_win_o), 6);

        // R7 then R11: write and call in the same cycle
        pulse_spill();
        we_i = 1; waddr_i = 5'(OB); wdata_i = 32'hC600; call_i = 1;
        step(); we_i = 0; call_i = 0;
        chk("R7 call after spill", 32'(cur_win_o), 7);
        rd_a("R11 write before move", IB, 32'hC600);

        // R12 wrap from window 7 to 0
        fill_locals(7);
        for (int k = 0; k < 6; k++) wr(OB + k, 32'hB700 + 32'(k));
        call_i = 1; #0.5;
        chk("R6 overflow again", 32'(ovf_trap_o), 1);
        chk("R6 oldest window 1", 32'(spill_win_o), 1);
        step(); call_i = 0;
        pulse_spill();
        good_call(0);
        for (int k = 0; k < 6; k++) rd_a("R12 ring wrap", IB + k, 32'hB700 + 32'(k));
        fill_locals(0);

        // R4 return down to window 2, checking privates of each window
        check_locals("R4 privates", 0);
        for (int t = 0; t < 6; t++) begin
            good_ret((8 - 1 - t) % 8 == 7 ? 7 : 7 - t);
            check_locals("R4 privates", 7 - t);
        end
        for (int g = 0; g < 8; g++) rd_b("R2 global late", GB + g, 32'h1000 + 32'(g));

        // R8 underflow at window 2, one resident
        ret_i = 1; #0.5;
        chk("R8 underflow trap", 32'(unf_trap_o), 1);
        chk("R8 fill window", 32'(fill_win_o), 1);
        step(); ret_i = 0;
        chk("R8 pointer held", 32'(cur_win_o), 2);

        // R9 fill-done then return accepted
        fill_done_i = 1; step(); fill_done_i = 0;
        good_ret(1);
        chk("R9 return after fill", 32'(cur_win_o), 1);
        check_locals("R9 privates", 1);

        // R10 same-cycle read of the register being written
        raddr_a_i = 5'(GB + 3);
        we_i = 1; waddr_i = 5'(GB + 3); wdata_i = 32'h5555AAAA;
        #0.5;
        chk("R10 old value", rdata_a_o, 32'h1003);
        step(); we_i = 0;
        chk("R10 new value", rdata_a_o, 32'h5555AAAA);

        // R13 invalid indices
        wr(30, 32'hDEAD0000);
        wr(31, 32'hDEAD0001);
        rd_a("R13 index 30", 30, 0);
        rd_a("R13 index 31", 31, 0);
        rd_b("R13 global 0 intact", GB, 32'h1000);
        check_locals("R13 privates intact", 1);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule